// File: doc/BRIEF.md
# Strobed Serial PCM Port with Width Autodetect

This block is a synchronous serial PCM port. It runs on a bit clock whose rate may vary. It has one serial input, one serial output with a drive enable for the pad, and an active-high strobe that frames each transfer. No configuration pins select the sample width. The block counts the rising bit-clock edges at which the strobe is high, and classifies the transfer from that count. A short strobe carries a companded byte and a long strobe carries a two's complement linear word.

The first frame of a legal length fixes the width. The width then stays fixed until reset. After that, a frame of the other legal length, or a frame of any illegal length, is rejected with an error pulse. Parallel words are left-justified in both directions. A narrow sample occupies the upper byte and the lower byte is zero.

Top module: `pcm_strobe_port`

## Requirements
- R1: After reset, `rx_valid_o`, `frame_err_o`, `locked_o` and `wide_o` are 0, `rx_word_o` is 0, and while `strobe_i` is low `sdat_oe_o` and `sdat_o` are 0.
- R2: A strobe high for exactly NARROW_W (8) edges is a legal narrow frame. The bits sampled at those edges, first bit most significant, appear in `rx_word_o[15:8]`, and `rx_word_o[7:0]` is 0.
- R3: A strobe high for exactly WIDE_W (16) edges is a legal wide frame. The 16 bits sampled, first bit most significant, appear in `rx_word_o[15:0]`.
- R4: `rx_valid_o` is high for exactly one cycle, in the cycle that follows the first edge at which the strobe is sampled low after a frame. `rx_word_o` changes only at that same edge.
- R5: The first accepted frame sets `locked_o` to 1. It also sets `wide_o` (1 for wide, 0 for narrow). Both hold until reset. A later legal frame of the other width gives a one-cycle `frame_err_o` and no `rx_valid_o`, and `rx_word_o` keeps its previous value.
- R6: A strobe of any length other than 8 or 16 edges gives a one-cycle `frame_err_o` and no `rx_valid_o`. `rx_word_o` is unchanged and the lock state is unchanged. Lengths above 16 are handled with a saturating count.
- R7: In strobe cycle k (k = 0 for the first cycle), `sdat_o` equals `tx_word_i[15-k]` for k < 16 and 0 after that, and `sdat_oe_o` is 1. `tx_word_i` is read in cycle 0 only.
- R8: Classification depends only on the count of edges with the strobe high. Idle gaps of any length, including two low cycles between strobes, leave the outputs and lock state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Bit clock, variable rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Transfer enable, active high |
| sdat_i | input | 1 | Serial receive data |
| tx_word_i | input | 16 | Left-justified word to transmit |
| sdat_o | output | 1 | Serial transmit data |
| sdat_oe_o | output | 1 | Pad drive enable; pad is high impedance when 0 |
| rx_word_o | output | 16 | Left-justified received word |
| rx_valid_o | output | 1 | One-cycle pulse for each accepted word |
| frame_err_o | output | 1 | One-cycle pulse for each rejected frame |
| locked_o | output | 1 | Width has been detected |
| wide_o | output | 1 | Detected width is 16 bits |

## Verification
The bench uses the default widths of 8 and 16. With these widths the edge counter is 5 bits wide. A 40-cycle strobe therefore drives the counter into saturation, and a 7-cycle strobe probes the value just below the narrow length. Stimulus vectors run strobes of 5, 7, 8, 16 and 40 cycles against a narrow lock. A reset in the middle of the run then allows a second lock on the wide width, followed by a narrow frame and a one-cycle strobe. Each frame is compared bit by bit on the transmit side and against a reference lock model on the receive side.

// File: rtl/pcm_strobe_pkg.sv
package pcm_strobe_pkg;
  typedef enum logic [1:0] {
    LEN_SHORT  = 2'd0,
    LEN_NARROW = 2'd1,
    LEN_WIDE   = 2'd2,
    LEN_BAD    = 2'd3
  } len_e;
endpackage

// File: rtl/pcm_strobe_meter.sv
module pcm_strobe_meter
  import pcm_strobe_pkg::*;
#(
  parameter int NARROW_W = 8,
  parameter int WIDE_W   = 16
) (
  input  logic bclk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic first_o,
  output logic end_o,
  output len_e len_o
);
  localparam int CNT_W = $clog2(WIDE_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX    = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] NARROW_CNT = CNT_W'(NARROW_W);
  localparam logic [CNT_W-1:0] WIDE_CNT   = CNT_W'(WIDE_W);

  logic             strb_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      strb_q <= strobe_i;
      if (!strobe_i)             cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign first_o = strobe_i & ~strb_q;
  assign end_o   = ~strobe_i & strb_q;

  always_comb begin
    if (cnt_q == NARROW_CNT)    len_o = LEN_NARROW;
    else if (cnt_q == WIDE_CNT) len_o = LEN_WIDE;
    else if (cnt_q < WIDE_CNT)  len_o = LEN_SHORT;
    else                        len_o = LEN_BAD;
  end

  // edge count restarts on every low cycle
  p_cnt_clear_r8: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    !strobe_i |=> cnt_q == '0);
  p_cnt_step_r6: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    (strobe_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  p_cnt_sat_r6: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    (strobe_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/pcm_rx_shifter.sv
module pcm_rx_shifter #(
  parameter int WIDE_W = 16
) (
  input  logic              bclk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              sdat_i,
  output logic [WIDE_W-1:0] shift_o
);
  always_ff @(posedge bclk_i or negedge rst_ni) begin
    if (!rst_ni)       shift_o <= '0;
    else if (strobe_i) shift_o <= {shift_o[WIDE_W-2:0], sdat_i};
  end

  p_rx_hold_r8: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(shift_o));
endmodule

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter #(
  parameter int WIDE_W = 16
) (
  input  logic              bclk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              first_i,
  input  logic [WIDE_W-1:0] tx_word_i,
  output logic              sdat_o,
  output logic              sdat_oe_o
);
  logic [WIDE_W-1:0] tx_sh_q;

  always_ff @(posedge bclk_i or negedge rst_ni) begin
    if (!rst_ni)       tx_sh_q <= '0;
    else if (first_i)  tx_sh_q <= {tx_word_i[WIDE_W-2:0], 1'b0};
    else if (strobe_i) tx_sh_q <= {tx_sh_q[WIDE_W-2:0], 1'b0};
  end

  // cycle 0 bypasses the register so the MSB is on the line at once
  assign sdat_o    = strobe_i & (first_i ? tx_word_i[WIDE_W-1] : tx_sh_q[WIDE_W-1]);
  assign sdat_oe_o = strobe_i;

  p_tx_load_r7: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    first_i |=> tx_sh_q[WIDE_W-1] == $past(tx_word_i[WIDE_W-2]));
  p_tx_idle_r1: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    !sdat_oe_o |-> !sdat_o);
endmodule

// File: rtl/pcm_width_lock.sv
module pcm_width_lock
  import pcm_strobe_pkg::*;
#(
  parameter int NARROW_W = 8,
  parameter int WIDE_W   = 16
) (
  input  logic              bclk_i,
  input  logic              rst_ni,
  input  logic              end_i,
  input  len_e              len_i,
  input  logic [WIDE_W-1:0] shift_i,
  output logic [WIDE_W-1:0] rx_word_o,
  output logic              rx_valid_o,
  output logic              frame_err_o,
  output logic              locked_o,
  output logic              wide_o
);
  logic [WIDE_W-1:0] narrow_word;
  logic              legal, is_wide, accept;

  generate
    if (NARROW_W < WIDE_W) begin : g_pad
      assign narrow_word = {shift_i[NARROW_W-1:0], {(WIDE_W-NARROW_W){1'b0}}};
    end else begin : g_full
      assign narrow_word = shift_i;
    end
  endgenerate

  assign legal   = (len_i == LEN_NARROW) || (len_i == LEN_WIDE);
  assign is_wide = (len_i == LEN_WIDE);
  assign accept  = legal && (!locked_o || (wide_o == is_wide));

  always_ff @(posedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_word_o   <= '0;
      rx_valid_o  <= 1'b0;
      frame_err_o <= 1'b0;
      locked_o    <= 1'b0;
      wide_o      <= 1'b0;
    end else begin
      rx_valid_o  <= end_i & accept;
      frame_err_o <= end_i & ~accept;
      if (end_i && accept) begin
        rx_word_o <= is_wide ? shift_i : narrow_word;
        locked_o  <= 1'b1;
        wide_o    <= is_wide;
      end
    end
  end

  p_lock_sticky_r5: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    locked_o |=> locked_o);
  p_wide_hold_r5: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    locked_o |=> $stable(wide_o));
  p_valid_locked_r4: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    rx_valid_o |-> locked_o);
  p_valid_err_excl_r6: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    !(rx_valid_o && frame_err_o));
  p_err_keeps_word_r6: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    frame_err_o |-> $stable(rx_word_o));
  p_valid_pulse_r4: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
endmodule

// File: rtl/pcm_strobe_port.sv
module pcm_strobe_port
  import pcm_strobe_pkg::*;
#(
  parameter int NARROW_W = 8,
  parameter int WIDE_W   = 16
) (
  input  logic              bclk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              sdat_i,
  input  logic [WIDE_W-1:0] tx_word_i,
  output logic              sdat_o,
  output logic              sdat_oe_o,
  output logic [WIDE_W-1:0] rx_word_o,
  output logic              rx_valid_o,
  output logic              frame_err_o,
  output logic              locked_o,
  output logic              wide_o
);
  logic              first, frame_end;
  len_e              len;
  logic [WIDE_W-1:0] rx_shift;

  pcm_strobe_meter #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_meter (
    .bclk_i, .rst_ni, .strobe_i,
    .first_o(first), .end_o(frame_end), .len_o(len)
  );

  pcm_rx_shifter #(.WIDE_W(WIDE_W)) u_rx (
    .bclk_i, .rst_ni, .strobe_i, .sdat_i, .shift_o(rx_shift)
  );

  pcm_tx_shifter #(.WIDE_W(WIDE_W)) u_tx (
    .bclk_i, .rst_ni, .strobe_i, .first_i(first), .tx_word_i,
    .sdat_o, .sdat_oe_o
  );

  pcm_width_lock #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_lock (
    .bclk_i, .rst_ni, .end_i(frame_end), .len_i(len), .shift_i(rx_shift),
    .rx_word_o, .rx_valid_o, .frame_err_o, .locked_o, .wide_o
  );
endmodule

// File: tb/sim_pcm_strobe_port.sv
module sim_pcm_strobe_port;
  logic        bclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b0;
  logic        sdi = 1'b0;
  logic [15:0] txw = '0;
  logic        sdo, sdo_oe, rx_valid, frame_err, locked, wide;
  logic [15:0] rx_word;

  int checks = 0;
  int fails  = 0;
  logic       m_locked = 1'b0;
  logic       m_wide   = 1'b0;
  logic [15:0] m_word  = '0;

  always #5 bclk = ~bclk;

  pcm_strobe_port u0 (
    .bclk_i(bclk), .rst_ni(rst_n), .strobe_i(strobe), .sdat_i(sdi),
    .tx_word_i(txw), .sdat_o(sdo), .sdat_oe_o(sdo_oe), .rx_word_o(rx_word),
    .rx_valid_o(rx_valid), .frame_err_o(frame_err), .locked_o(locked),
    .wide_o(wide)
  );

  // {len, rx data (left-justified), tx word, extra idle cycles}
  localparam logic [47:0] VEC [8] = '{
    {8'd5,  16'hAAAA, 16'h1234, 8'd0},
    {8'd8,  16'hA500, 16'hC3FF, 8'd2},
    {8'd8,  16'h3C11, 16'h5A00, 8'd0},
    {8'd16, 16'hBEEF, 16'h8001, 8'd1},
    {8'd40, 16'hFFFF, 16'hFFFF, 8'd3},
    {8'd8,  16'h81C4, 16'h7E00, 8'd5},
    {8'd7,  16'hF000, 16'h0F00, 8'd0},
    {8'd8,  16'h0100, 16'h8000, 8'd0}
  };

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input int len, input logic [15:0] rxd,
                           input logic [15:0] txd, input int gap);
    int  tx_bad = 0;
    logic legal, acc, is_wide;
    for (int k = 0; k < len; k++) begin
      @(negedge bclk);
      strobe = 1'b1;
      txw = (k == 0) ? txd : ~txd;  // only cycle 0 may matter
      sdi = (k < 16) ? rxd[15-k] : 1'b0;
      #1;
      if (!sdo_oe || sdo !== ((k < 16) ? txd[15-k] : 1'b0)) tx_bad++;
    end
    chk(tx_bad == 0, "R7 tx bit stream", tx_bad, 0);
    @(negedge bclk);
    strobe = 1'b0;
    sdi = 1'b1;
    #1;
    chk(!sdo_oe && !sdo, "R7 idle line", {sdo_oe, sdo}, 0);
    chk(!rx_valid && rx_word == m_word, "R4 no early update", {rx_valid, rx_word}, {1'b0, m_word});
    legal   = (len == 8) || (len == 16);
    is_wide = (len == 16);
    acc     = legal && (!m_locked || m_wide == is_wide);
    if (acc) begin
      m_word   = is_wide ? rxd : {rxd[15:8], 8'h00};
      m_locked = 1'b1;
      m_wide   = is_wide;
    end
    @(negedge bclk);
    #1;
    if (acc)
      chk(rx_valid && !frame_err && rx_word == m_word,
          is_wide ? "R3 wide word" : "R2 narrow word", {rx_valid, frame_err, rx_word},
          {2'b10, m_word});
    else
      chk(!rx_valid && frame_err && rx_word == m_word,
          legal ? "R5 width mismatch" : "R6 bad length", {rx_valid, frame_err, rx_word},
          {2'b01, m_word});
    chk(locked == m_locked && wide == m_wide, "R5 lock state", {locked, wide},
        {m_locked, m_wide});
    @(negedge bclk);
    #1;
    chk(!rx_valid && !frame_err, "R4 single pulse", {rx_valid, frame_err}, 0);
    for (int g = 0; g < gap; g++) begin
      @(negedge bclk);
      #1;
      chk(!rx_valid && !frame_err && rx_word == m_word && locked == m_locked,
          "R8 idle gap", {rx_valid, frame_err, locked, rx_word},
          {2'b00, m_locked, m_word});
    end
  endtask

  initial begin
    repeat (200000) @(posedge bclk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge bclk);
    #1;
    chk(!rx_valid && !frame_err && !locked && !wide && rx_word == 0 && !sdo_oe && !sdo,
        "R1 reset state", {rx_valid, frame_err, locked, wide, sdo_oe, sdo, rx_word}, 0);
    @(negedge bclk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++)
      run_frame(int'(VEC[i][47:40]), VEC[i][39:24], VEC[i][23:8], int'(VEC[i][7:0]));

    // reset mid-run, then lock wide
    @(negedge bclk);
    rst_n = 1'b0;
    m_locked = 1'b0; m_wide = 1'b0; m_word = '0;
    @(negedge bclk);
    #1;
    chk(!rx_valid && !frame_err && !locked && !wide && rx_word == 0,
        "R1 reset clears lock", {rx_valid, frame_err, locked, wide, rx_word}, 0);
    @(negedge bclk);
    rst_n = 1'b1;
    run_frame(16, 16'h9C3A, 16'hA55A, 0);
    run_frame(8,  16'h7700, 16'hFF00, 1);
    run_frame(1,  16'h8000, 16'h8000, 0);
    run_frame(16, 16'h0001, 16'h0001, 4);
    run_frame(17, 16'hFFFF, 16'h1111, 0);
    run_frame(16, 16'h8421, 16'hFEDC, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule